// File: doc/BRIEF.md
# Two-Level Request Priority Generator for One Input Port

This block sits at one input of an N-by-N input-queued crossbar scheduler. It is clocked at a steady rate. Once per scheduling slot, marked by a one-cycle strobe, it reads four things: which of the port's virtual output queues hold cells, whether the port won a match in the previous slot and to which output, and a saturating wait age per queue. From these it produces a two-bit priority for each queue. The grant arbiters at the outputs consume these priorities.

A rotating pairing rule ties this input to one output per slot. Output `j` is paired with input `i` when `j = (i + t) mod N`, where `t` is a slot counter kept inside the block. The rule and the previous match decide whether a held connection keeps its strong claim or yields it to other inputs. An age beyond a limit forces a queue back to strong so that it cannot starve. Grant, accept, queue storage and the crossbar itself live elsewhere.

Top module: `voq_req_gen`

## Requirements
- R1: Each queue's priority field is two bits wide. Queue `k` occupies bits `2k+1:2k` of `req_prio`. The value 2 means strong, 1 means weak and 0 means no request. The value 3 never appears.
- R2: While reset is asserted, all priority fields read 0. At the first slot strobe after reset, every non-empty queue below the age limit is classified strong.
- R3: At later strobes with `prev_matched` high, the queue whose index equals `prev_out` is classified weak, provided that `prev_out` equals `(port_id + t) mod N`.
- R4: At later strobes with `prev_matched` high, a non-empty queue gets strong in two cases: its index differs from `prev_out`, or `prev_out` fails the pairing rule.
- R5: A non-empty queue whose age is strictly greater than `AGE_LIMIT` is classified strong, whatever the other inputs are. An age equal to the limit has no such effect.
- R6: At later strobes with `prev_matched` low, every non-empty queue at or below the age limit is classified weak.
- R7: An empty queue is classified 0, even when its age is above the limit.
- R8: The slot counter `t` is 0 after reset. It advances by one at each strobe, after that strobe has been classified, and it wraps from N-1 to 0.
- R9: New priorities appear at the clock edge that samples the strobe. They hold unchanged until the next strobe, even when the inputs change in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_strobe | input | 1 | One-cycle slot marker; priorities are computed at this edge |
| port_id | input | IDX_W | Index `i` of this input port |
| voq_nonempty | input | N_PORTS | Occupancy flag per queue |
| prev_matched | input | 1 | Port was matched in the previous slot |
| prev_out | input | IDX_W | Output matched in the previous slot |
| voq_age | input | AGE_W*N_PORTS | Saturating wait age per queue, queue `k` at bits `AGE_W*k +: AGE_W` |
| req_prio | output | 2*N_PORTS | Registered priority per queue |

## Verification
Two effects can act on one queue in the same slot. The pairing rule can demote a held connection to weak, and the age override can force that same queue to strong. The bench provokes this by holding a match on the paired output while giving that queue an age above the limit. It expects strong. A second collision happens at counter wrap. The slot counter returns to zero in the same slot in which a match must be demoted, so the bench judges the demotion against the wrapped value of `t`.

// File: rtl/voq_req_pkg.sv
package voq_req_pkg;

   typedef enum logic [1:0] {
      PRIO_NONE   = 2'd0,
      PRIO_WEAK   = 2'd1,
      PRIO_STRONG = 2'd2
   } prio_e;

endpackage

// File: rtl/voq_slot_ctr.sv
module voq_slot_ctr #(
   parameter int N_PORTS = 4,
   localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_strobe,
   output logic [IDX_W-1:0] slot_t,
   output logic             first_slot
);

   localparam bit IS_POW2 = (N_PORTS & (N_PORTS - 1)) == 0;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PORTS - 1);

   logic [IDX_W-1:0] t_nxt;

   generate
      if (IS_POW2) begin : g_pow2_wrap
         assign t_nxt = slot_t + 1'b1;
      end else begin : g_cmp_wrap
         assign t_nxt = (slot_t == LAST) ? '0 : slot_t + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_t     <= '0;
         first_slot <= 1'b1;
      end else if (slot_strobe) begin
         slot_t     <= t_nxt;
         first_slot <= 1'b0;
      end
   end

endmodule

// File: rtl/voq_prio_cell.sv
module voq_prio_cell
   import voq_req_pkg::*;
#(
   parameter int AGE_LIMIT = 50,
   parameter int AGE_W     = 6
) (
   input  logic             nonempty,
   input  logic [AGE_W-1:0] age,
   input  logic             first_slot,
   input  logic             matched,
   input  logic             pair_hit,
   output prio_e            prio
);

   logic overdue;
   assign overdue = int'({1'b0, age}) > AGE_LIMIT;

   always_comb begin
      if (!nonempty)        prio = PRIO_NONE;
      else if (overdue)     prio = PRIO_STRONG;
      else if (first_slot)  prio = PRIO_STRONG;
      else if (!matched)    prio = PRIO_WEAK;
      else if (pair_hit)    prio = PRIO_WEAK;
      else                  prio = PRIO_STRONG;
   end

endmodule

// File: rtl/voq_req_gen.sv
module voq_req_gen
   import voq_req_pkg::*;
#(
   parameter int N_PORTS   = 4,
   parameter int AGE_LIMIT = 50,
   parameter int AGE_W     = $clog2(AGE_LIMIT + 1),
   localparam int IDX_W    = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     slot_strobe,
   input  logic [IDX_W-1:0]         port_id,
   input  logic [N_PORTS-1:0]       voq_nonempty,
   input  logic                     prev_matched,
   input  logic [IDX_W-1:0]         prev_out,
   input  logic [AGE_W*N_PORTS-1:0] voq_age,
   output logic [2*N_PORTS-1:0]     req_prio
);

   generate
      if (N_PORTS < 2) begin : g_bad_ports
         $error("voq_req_gen: N_PORTS must be at least 2");
      end
      if (AGE_W < $clog2(AGE_LIMIT + 1)) begin : g_bad_age_w
         $error("voq_req_gen: AGE_W too narrow for AGE_LIMIT");
      end
   endgenerate

   logic [IDX_W-1:0] slot_t;
   logic             first_slot;

   voq_slot_ctr #(.N_PORTS(N_PORTS)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_strobe(slot_strobe),
      .slot_t     (slot_t),
      .first_slot (first_slot)
   );

   // pairing rule: output (port_id + t) mod N
   logic [IDX_W:0]   pair_sum;
   logic [IDX_W-1:0] pair_out;
   logic             pair_ok;

   assign pair_sum = {1'b0, port_id} + {1'b0, slot_t};
   assign pair_out = (pair_sum >= (IDX_W+1)'(N_PORTS))
                   ? IDX_W'(pair_sum - (IDX_W+1)'(N_PORTS))
                   : pair_sum[IDX_W-1:0];
   assign pair_ok  = (pair_out == prev_out);

   logic [2*N_PORTS-1:0] prio_d;

   generate
      for (genvar k = 0; k < N_PORTS; k++) begin : g_voq
         localparam logic [IDX_W-1:0] K_IDX = IDX_W'(k);
         prio_e cell_prio;

         voq_prio_cell #(.AGE_LIMIT(AGE_LIMIT), .AGE_W(AGE_W)) u_cell (
            .nonempty  (voq_nonempty[k]),
            .age       (voq_age[AGE_W*k +: AGE_W]),
            .first_slot(first_slot),
            .matched   (prev_matched),
            .pair_hit  (pair_ok && (prev_out == K_IDX)),
            .prio      (cell_prio)
         );

         assign prio_d[2*k +: 2] = cell_prio;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           req_prio <= '0;
      else if (slot_strobe) req_prio <= prio_d;
   end

endmodule

// File: rtl/voq_req_gen_chk.sv
module voq_req_gen_chk #(
   parameter int N_PORTS   = 4,
   parameter int AGE_LIMIT = 50,
   parameter int AGE_W     = 6
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     slot_strobe,
   input logic [N_PORTS-1:0]       voq_nonempty,
   input logic                     prev_matched,
   input logic [AGE_W*N_PORTS-1:0] voq_age,
   input logic [2*N_PORTS-1:0]     req_prio
);

   logic seen_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           seen_q <= 1'b0;
      else if (slot_strobe) seen_q <= 1'b1;
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_strobe |=> $stable(req_prio));

   generate
      for (genvar k = 0; k < N_PORTS; k++) begin : g_k
         logic over;
         assign over = int'({1'b0, voq_age[AGE_W*k +: AGE_W]}) > AGE_LIMIT;

         p_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
            req_prio[2*k +: 2] != 2'd3);

         p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
            slot_strobe && !voq_nonempty[k] |=> req_prio[2*k +: 2] == 2'd0);

         p_aged_r5: assert property (@(posedge clk) disable iff (!rst_n)
            slot_strobe && voq_nonempty[k] && over |=> req_prio[2*k +: 2] == 2'd2);

         p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
            slot_strobe && !seen_q && voq_nonempty[k] |=> req_prio[2*k +: 2] == 2'd2);

         p_unmatched_r6: assert property (@(posedge clk) disable iff (!rst_n)
            slot_strobe && seen_q && !prev_matched && voq_nonempty[k] && !over
            |=> req_prio[2*k +: 2] == 2'd1);
      end
   endgenerate

endmodule

bind voq_req_gen voq_req_gen_chk #(
   .N_PORTS  (N_PORTS),
   .AGE_LIMIT(AGE_LIMIT),
   .AGE_W    (AGE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .slot_strobe (slot_strobe),
   .voq_nonempty(voq_nonempty),
   .prev_matched(prev_matched),
   .voq_age     (voq_age),
   .req_prio    (req_prio)
);

// File: tb/voq_req_gen_bench.sv
`timescale 1ns/1ps
module voq_req_gen_bench;

   localparam int N  = 4;
   localparam int A  = 50;
   localparam int AW = 6;
   localparam int IW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            slot_strobe = 1'b0;
   logic [IW-1:0]   port_id = 2'd1;
   logic [N-1:0]    voq_nonempty = '0;
   logic            prev_matched = 1'b0;
   logic [IW-1:0]   prev_out = '0;
   logic [AW*N-1:0] voq_age = '0;
   logic [2*N-1:0]  req_prio;

   always #2 clk = ~clk;

   voq_req_gen #(.N_PORTS(N), .AGE_LIMIT(A), .AGE_W(AW)) u_voq_req_gen (
      .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe), .port_id(port_id),
      .voq_nonempty(voq_nonempty), .prev_matched(prev_matched),
      .prev_out(prev_out), .voq_age(voq_age), .req_prio(req_prio)
   );

   int checks = 0;
   int fails  = 0;

   logic [2*N-1:0] exp_q[$];
   string          tag_q[$];
   logic [2*N-1:0] last_exp = '0;

   int t_m     = 0;
   bit first_m = 1'b1;

   task automatic check_vec(input logic [2*N-1:0] act, input logic [2*N-1:0] exp,
                            input string tag);
      for (int k = 0; k < N; k++) begin
         checks++;
         if (act[2*k +: 2] !== exp[2*k +: 2]) begin
            fails++;
            $display("FAIL %s voq%0d actual=%0d expected=%0d", tag, k,
                     act[2*k +: 2], exp[2*k +: 2]);
         end
      end
   endtask

   // expectation from the requirements (R1 codes 2/1/0)
   function automatic logic [2*N-1:0] predict(input logic [N-1:0] ne, input bit m,
                                              input int po, input logic [AW*N-1:0] ages);
      logic [2*N-1:0] v;
      int pair;
      pair = (1 + t_m) % N;
      for (int k = 0; k < N; k++) begin
         int age;
         age = int'(ages[AW*k +: AW]);
         if (!ne[k])                       v[2*k +: 2] = 2'd0;
         else if (age > A)                 v[2*k +: 2] = 2'd2;
         else if (first_m)                 v[2*k +: 2] = 2'd2;
         else if (!m)                      v[2*k +: 2] = 2'd1;
         else if (k == po && po == pair)   v[2*k +: 2] = 2'd1;
         else                              v[2*k +: 2] = 2'd2;
      end
      return v;
   endfunction

   task automatic do_slot(input logic [N-1:0] ne, input bit m, input int po,
                          input logic [AW*N-1:0] ages, input string tag);
      @(negedge clk);
      voq_nonempty = ne;
      prev_matched = m;
      prev_out     = IW'(po);
      voq_age      = ages;
      exp_q.push_back(predict(ne, m, po, ages));
      tag_q.push_back(tag);
      t_m     = (t_m + 1) % N;
      first_m = 1'b0;
      slot_strobe = 1'b1;
      @(negedge clk);
      slot_strobe = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // monitor: pops one expectation per strobe, samples at the next negedge
   initial begin
      forever begin
         @(posedge clk);
         if (slot_strobe && rst_n) begin
            logic [2*N-1:0] e;
            string tg;
            @(negedge clk);
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            last_exp = e;
            check_vec(req_prio, e, tg);
         end
      end
   end

   function automatic logic [AW*N-1:0] ages4(input int a0, input int a1,
                                             input int a2, input int a3);
      return {AW'(a3), AW'(a2), AW'(a1), AW'(a0)};
   endfunction

   initial begin
      #(4 * 20000);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_vec(req_prio, '0, "R2 reset zero");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 first slot strong, R7 empty queue 2
      do_slot(4'b1011, 1'b0, 0, ages4(0, 0, 0, 0), "R2 first-slot strong / R7");
      // R6 unmatched -> weak (t=1)
      do_slot(4'b1111, 1'b0, 0, ages4(3, 3, 3, 3), "R6 unmatched weak");
      // R3 matched on paired output 3 (t=2)
      do_slot(4'b1111, 1'b1, 3, ages4(1, 2, 3, 4), "R3 pair demote");
      // R4 matched on 3 but pair is 0 (t=3)
      do_slot(4'b1111, 1'b1, 3, ages4(1, 2, 3, 4), "R4 no pair strong");
      // R8 wrap: t back to 0, pair is 1
      do_slot(4'b0110, 1'b1, 1, ages4(0, 9, 9, 0), "R8 wrap pair demote");
      // R5 age 51 overrides, age 50 does not; R7 empty with max age (t=1)
      do_slot(4'b1011, 1'b0, 0, ages4(51, 50, 63, 0), "R5 age limit / R7");
      // R5 collides with R3 on queue 3 (t=2, pair 3)
      do_slot(4'b1100, 1'b1, 3, ages4(0, 0, 0, 63), "R5 over R3 collision");

      // R9 hold: change inputs, no strobe
      voq_nonempty = 4'b0000;
      prev_matched = 1'b1;
      voq_age      = '1;
      repeat (4) @(negedge clk);
      check_vec(req_prio, last_exp, "R9 hold without strobe");

      // R2 reset mid-run, then first slot strong again with t=0 (R8)
      rst_n = 1'b0;
      @(negedge clk);
      check_vec(req_prio, '0, "R2 reset clears");
      rst_n   = 1'b1;
      t_m     = 0;
      first_m = 1'b1;
      @(negedge clk);
      do_slot(4'b0101, 1'b1, 1, ages4(0, 0, 0, 0), "R2 strong after reset");
      do_slot(4'b1110, 1'b1, 2, ages4(0, 0, 0, 0), "R8 restart t=1 pair demote");

      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule